// File: doc/BRIEF.md
# Modulo-Wrapping Memory-to-Memory DMA Engine

A single-channel DMA engine that copies words from one memory region to another. Software fills a small descriptor register set with the following fields:

- the two start addresses;
- signed per-beat address steps;
- beat size codes;
- per-side modulo fields;
- a byte count for one minor loop;
- an iteration count for the major loop;
- signed address corrections applied when the whole transfer ends.

A start pulse launches the transfer. The engine then alternates a read and a write on a single memory port whose read data appears one cycle after the request. It runs every minor loop of the major loop back to back.

Each address can be held inside an aligned power-of-two window. The low bits advance and the high bits stay fixed. A short aligned source table can therefore be replayed across a longer destination, or a destination can be kept inside a small ring. At the end of the transfer the engine sets a completion flag and, if enabled, an interrupt flag. Both are cleared by writing ones to the status register. Descriptors that cannot be executed raise an error flag, and no memory access takes place.

Top module: `dma_mw_top`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `irq`, `err` and `mem_en` are 0, and the status register (index 8) reads 0.
- R2: Register indices are 0 source address, 1 destination address, 2 offsets, 3 attributes, 4 minor byte count, 5 iteration count, 6 source end correction, 7 destination end correction and 8 status. Writes to indices 0–7 take effect only while `busy` is 0; a write during a transfer leaves the register unchanged.
- R3: Each beat is one read cycle at the source address followed by one write cycle at the destination address, carrying the word read. A transfer of N beats started by a pulse sampled at edge E0 sets `done` at edge E0+2N.
- R4: The offsets register holds the signed source step in bits 15:0 and the signed destination step in bits 31:16. Each address moves by its own step after every beat.
- R5: Attribute bits 4:0 (source) and 12:8 (destination) give a modulo value n. A nonzero n lets an address change only in its low n bits, so it wraps inside an aligned 2^n-byte window. 0 disables wrapping.
- R6: Index 5 loads both the current and the reload iteration count. Readback returns the current count in bits 31:16 and the reload count in bits 15:0. One start runs all iterations, each moving the index-4 byte count. At the end the current count is restored from the reload count.
- R7: After the final beat of the major loop, each address also receives its signed end correction (indices 6 and 7).
- R8: At major-loop completion `done` sets. `irq` sets as well when attribute bit 31 is 1, and stays unchanged otherwise.
- R9: Writing the status register clears `done`, `irq` and `err` for each 1 in bits 0, 1 and 2 respectively. Status bit 3 reads `busy`.
- R10: A start pulse while `busy` is 1 has no effect on the running transfer or its length.
- R11: Any of the following is a configuration error: a byte count of 0, a byte count that is not a multiple of 4, an iteration count of 0, or a source or destination size code (attribute bits 18:16 and 26:24) other than 2 (4-byte word). On a start with a configuration error, `err` sets, `done` is unchanged and no memory access occurs.
- R12: With a 16-byte aligned source holding 1,2,3,4, a source modulo of 4, steps of +4 and a 32-byte transfer, the destination holds 1,2,3,4,1,2,3,4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Software start pulse |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index for write and readback |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered readback of the indexed register |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Major-loop completion flag |
| irq | output | 1 | Interrupt flag |
| err | output | 1 | Configuration error flag |

## Verification
The bench builds the engine with its defaults: 32-bit addresses and 16-bit counts. With 16-bit counts, both iteration counts fit side by side in one readback word, so the reload after completion is visible through the register port. The bench memory decodes only eight word-index bits. All scenarios therefore sit below address 0x400, and the 8- and 16-byte modulo windows, descending source steps and multi-iteration runs all fit inside that memory.

// File: rtl/dma_mw_pkg.sv
`timescale 1ns/1ps
package dma_mw_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} dma_st_t;

  localparam logic [3:0] RA_SRC    = 4'd0;
  localparam logic [3:0] RA_DST    = 4'd1;
  localparam logic [3:0] RA_OFF    = 4'd2;
  localparam logic [3:0] RA_ATTR   = 4'd3;
  localparam logic [3:0] RA_NBYTES = 4'd4;
  localparam logic [3:0] RA_ITER   = 4'd5;
  localparam logic [3:0] RA_SLAST  = 4'd6;
  localparam logic [3:0] RA_DLAST  = 4'd7;
  localparam logic [3:0] RA_STAT   = 4'd8;

  localparam logic [2:0] SZ_WORD    = 3'd2;
  localparam int         BEAT_BYTES = 4;

  typedef struct packed {
    logic       irq_en;
    logic [2:0] dsize;
    logic [2:0] ssize;
    logic [4:0] dmod;
    logic [4:0] smod;
  } dma_attr_t;

  function automatic dma_attr_t attr_unpack(input logic [31:0] w);
    dma_attr_t a;
    a.irq_en = w[31];
    a.dsize  = w[26:24];
    a.ssize  = w[18:16];
    a.dmod   = w[12:8];
    a.smod   = w[4:0];
    return a;
  endfunction

  function automatic logic [31:0] attr_pack(input dma_attr_t a);
    return {a.irq_en, 4'b0, a.dsize, 5'b0, a.ssize, 3'b0, a.dmod, 3'b0, a.smod};
  endfunction
endpackage

// File: rtl/dma_mw_addr.sv
`timescale 1ns/1ps
module dma_mw_addr #(
  parameter int AW = 32
) (
  input  logic [AW-1:0]       cur,
  input  logic signed [15:0]  off,
  input  logic [4:0]          modsel,
  output logic [AW-1:0]       nxt
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] sum;
  logic [AW-1:0] mask;

  always_comb begin
    sum  = cur + {{(AW-16){off[15]}}, off};
    mask = (modsel == 5'd0) ? '1 : ((ONE << modsel) - ONE);
    nxt  = (cur & ~mask) | (sum & mask);
  end

  always_comb begin
    if (modsel != 5'd0) begin
      AST_MOD_WINDOW: assert ((nxt >> modsel) == (cur >> modsel)); // R5
    end
  end
endmodule

// File: rtl/dma_mw_regs.sv
`timescale 1ns/1ps
module dma_mw_regs
  import dma_mw_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              idle,
  input  logic [3:0]        stat_bits,
  input  logic              upd_addr,
  input  logic [AW-1:0]     nxt_src,
  input  logic [AW-1:0]     nxt_dst,
  input  logic              upd_iter,
  input  logic [CW-1:0]     nxt_citer,
  output logic [AW-1:0]     src_addr,
  output logic [AW-1:0]     dst_addr,
  output logic signed [15:0] src_off,
  output logic signed [15:0] dst_off,
  output dma_attr_t         attr,
  output logic [CW-1:0]     nbytes,
  output logic [CW-1:0]     citer,
  output logic [CW-1:0]     biter,
  output logic [AW-1:0]     slast,
  output logic [AW-1:0]     dlast
);
  logic        wr_ok;
  logic [31:0] rd_mux;

  assign wr_ok = cfg_we && idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_addr <= '0; dst_addr <= '0;
      src_off  <= '0; dst_off  <= '0;
      attr     <= '0; nbytes   <= '0;
      citer    <= '0; biter    <= '0;
      slast    <= '0; dlast    <= '0;
    end else if (wr_ok) begin
      case (cfg_addr)
        RA_SRC:    src_addr <= cfg_wdata[AW-1:0];
        RA_DST:    dst_addr <= cfg_wdata[AW-1:0];
        RA_OFF:    begin src_off <= cfg_wdata[15:0]; dst_off <= cfg_wdata[31:16]; end
        RA_ATTR:   attr <= attr_unpack(cfg_wdata);
        RA_NBYTES: nbytes <= cfg_wdata[CW-1:0];
        RA_ITER:   begin citer <= cfg_wdata[CW-1:0]; biter <= cfg_wdata[CW-1:0]; end
        RA_SLAST:  slast <= cfg_wdata[AW-1:0];
        RA_DLAST:  dlast <= cfg_wdata[AW-1:0];
        default:   ;
      endcase
    end else begin
      if (upd_addr) begin
        src_addr <= nxt_src;
        dst_addr <= nxt_dst;
      end
      if (upd_iter) citer <= nxt_citer;
    end
  end

  always_comb begin
    case (cfg_addr)
      RA_SRC:    rd_mux = 32'(src_addr);
      RA_DST:    rd_mux = 32'(dst_addr);
      RA_OFF:    rd_mux = {dst_off, src_off};
      RA_ATTR:   rd_mux = attr_pack(attr);
      RA_NBYTES: rd_mux = 32'(nbytes);
      RA_ITER:   rd_mux = 32'({citer, biter});
      RA_SLAST:  rd_mux = 32'(slast);
      RA_DLAST:  rd_mux = 32'(dlast);
      RA_STAT:   rd_mux = 32'(stat_bits);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_mux;
  end

  AST_DESC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!idle && !upd_addr) |=> $stable(src_addr)); // R2
endmodule

// File: rtl/dma_mw_ctrl.sv
`timescale 1ns/1ps
module dma_mw_ctrl
  import dma_mw_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    clr,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [AW-1:0] step_src,
  input  logic [AW-1:0] step_dst,
  input  logic [AW-1:0] slast,
  input  logic [AW-1:0] dlast,
  input  logic [CW-1:0] nbytes,
  input  logic [CW-1:0] citer,
  input  logic [CW-1:0] biter,
  input  logic [2:0]    ssize,
  input  logic [2:0]    dsize,
  input  logic          irq_en,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic          err,
  output logic          upd_addr,
  output logic [AW-1:0] nxt_src,
  output logic [AW-1:0] nxt_dst,
  output logic          upd_iter,
  output logic [CW-1:0] nxt_citer,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr
);
  localparam logic [CW-1:0] BEAT = CW'(BEAT_BYTES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  dma_st_t       st;
  logic [CW-1:0] left;
  logic          cfg_bad, launch, in_wr, last_beat, last_major;
  logic          set_done, set_err;

  always_comb begin
    cfg_bad    = ((nbytes & (BEAT - ONE)) != '0) || (nbytes == '0) || (citer == '0) ||
                 (ssize != SZ_WORD) || (dsize != SZ_WORD);
    launch     = (st == ST_IDLE) && start;
    in_wr      = (st == ST_WR);
    last_beat  = (left == BEAT);
    last_major = last_beat && (citer == ONE);
    set_done   = in_wr && last_major;
    set_err    = launch && cfg_bad;
    upd_addr   = in_wr;
    nxt_src    = last_major ? step_src + slast : step_src;
    nxt_dst    = last_major ? step_dst + dlast : step_dst;
    upd_iter   = in_wr && last_beat;
    nxt_citer  = last_major ? biter : citer - ONE;
    busy       = (st != ST_IDLE);
    mem_en     = busy;
    mem_we     = in_wr;
    mem_addr   = in_wr ? dst_addr : src_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      left <= '0;
      done <= 1'b0;
      irq  <= 1'b0;
      err  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (launch && !cfg_bad) begin
          st   <= ST_RD;
          left <= nbytes;
        end
        ST_RD: st <= ST_WR;
        ST_WR: begin
          if (last_major) st <= ST_IDLE;
          else begin
            st   <= ST_RD;
            left <= last_beat ? nbytes : left - BEAT;
          end
        end
        default: st <= ST_IDLE;
      endcase
      done <= set_done | (done & ~clr[0]);
      irq  <= (set_done & irq_en) | (irq & ~clr[1]);
      err  <= set_err | (err & ~clr[2]);
    end
  end

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(mem_en && !mem_we)); // R3
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (!busy && $past(busy))); // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(irq_en) && done)); // R8
  AST_ERR_NO_MOTION: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (!busy && !$past(busy))); // R11
endmodule

// File: rtl/dma_mw_top.sv
`timescale 1ns/1ps
module dma_mw_top
  import dma_mw_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic          err
);
  logic [AW-1:0] src_addr, dst_addr, slast, dlast, nxt_src, nxt_dst;
  logic signed [15:0] src_off, dst_off;
  dma_attr_t     attr;
  logic [CW-1:0] nbytes, citer, biter, nxt_citer;
  logic          upd_addr, upd_iter;
  logic [2:0]    clr;

  logic [1:0][AW-1:0] cur_a, step_a;
  logic [1:0][15:0]   off_a;
  logic [1:0][4:0]    mod_a;

  assign clr       = (cfg_we && cfg_addr == RA_STAT) ? cfg_wdata[2:0] : 3'b000;
  assign mem_wdata = mem_rdata;

  assign cur_a = {dst_addr, src_addr};
  assign off_a = {dst_off, src_off};
  assign mod_a = {attr.dmod, attr.smod};

  generate
    for (genvar s = 0; s < 2; s++) begin : g_side
      dma_mw_addr #(.AW(AW)) u_step (
        .cur(cur_a[s]), .off(off_a[s]), .modsel(mod_a[s]), .nxt(step_a[s])
      );
    end
  endgenerate

  dma_mw_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .idle(!busy), .stat_bits({busy, err, irq, done}),
    .upd_addr(upd_addr), .nxt_src(nxt_src), .nxt_dst(nxt_dst),
    .upd_iter(upd_iter), .nxt_citer(nxt_citer),
    .src_addr(src_addr), .dst_addr(dst_addr), .src_off(src_off), .dst_off(dst_off),
    .attr(attr), .nbytes(nbytes), .citer(citer), .biter(biter), .slast(slast), .dlast(dlast)
  );

  dma_mw_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .clr(clr),
    .src_addr(src_addr), .dst_addr(dst_addr), .step_src(step_a[0]), .step_dst(step_a[1]),
    .slast(slast), .dlast(dlast), .nbytes(nbytes), .citer(citer), .biter(biter),
    .ssize(attr.ssize), .dsize(attr.dsize), .irq_en(attr.irq_en),
    .busy(busy), .done(done), .irq(irq), .err(err),
    .upd_addr(upd_addr), .nxt_src(nxt_src), .nxt_dst(nxt_dst),
    .upd_iter(upd_iter), .nxt_citer(nxt_citer),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr)
  );
endmodule

// File: tb/dma_mw_top_test.sv
`timescale 1ns/1ps
module dma_mw_top_test;
  import dma_mw_pkg::*;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        start = 0, cfg_we = 0;
  logic [3:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata, mem_wdata, mem_rdata = 0;
  logic [AW-1:0] mem_addr;
  logic        mem_en, mem_we, busy, done, irq, err;

  dma_mw_top #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .start(start), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .irq(irq), .err(err)
  );

  logic [31:0] ram     [0:255];
  logic [31:0] ref_ram [0:255];
  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) ram[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr[9:2]];
    end

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model state
  logic [31:0] q_ra[$], q_wa[$], q_wd[$];
  logic [31:0] m_src, m_dst, m_slast, m_dlast;
  int m_soff, m_doff, m_smod, m_dmod, m_nb, m_it, beats;
  logic [31:0] ea, ed;

  // Per-cycle comparison of every memory access against the model's stream
  always @(negedge clk)
    if (!rst && mem_en) begin
      if (mem_we) begin
        if (q_wa.size() == 0) chk(0, "R3 unexpected write", mem_addr, 32'h0);
        else begin
          ea = q_wa.pop_front(); ed = q_wd.pop_front();
          chk(mem_addr == ea, "R5 write address", mem_addr, ea);
          chk(mem_wdata == ed, "R3 write data", mem_wdata, ed);
        end
      end else begin
        if (q_ra.size() == 0) chk(0, "R11 unexpected read", mem_addr, 32'h0);
        else begin
          ea = q_ra.pop_front();
          chk(mem_addr == ea, "R4 read address", mem_addr, ea);
        end
      end
    end

  function automatic logic [31:0] mstep(input logic [31:0] a, input int off, input int m);
    longint win, base, pos;
    if (m == 0) return a + 32'(off);
    win  = longint'(1) << m;
    base = longint'(a) - (longint'(a) % win);
    pos  = ((longint'(a) - base + off) % win + win) % win;
    return 32'(base + pos);
  endfunction

  task automatic model_run();
    logic [31:0] d;
    beats = 0;
    for (int it = 0; it < m_it; it++)
      for (int b = 0; b < m_nb / 4; b++) begin
        q_ra.push_back(m_src);
        d = ref_ram[m_src[9:2]];
        q_wa.push_back(m_dst);
        q_wd.push_back(d);
        ref_ram[m_dst[9:2]] = d;
        m_src = mstep(m_src, m_soff, m_smod);
        m_dst = mstep(m_dst, m_doff, m_dmod);
        beats++;
      end
    m_src = m_src + m_slast;
    m_dst = m_dst + m_dlast;
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] v);
    ram[a[9:2]] = v;
    ref_ram[a[9:2]] = v;
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); cfg_we = 0; cfg_addr = a;
    @(negedge clk); v = cfg_rdata;
  endtask

  task automatic prog(input logic [31:0] s, input logic [31:0] d, input int so, input int dof,
                      input int sm, input int dm, input int ss, input int ds, input bit ie,
                      input int nb, input int it, input logic [31:0] sl, input logic [31:0] dl);
    m_src = s; m_dst = d; m_soff = so; m_doff = dof; m_smod = sm; m_dmod = dm;
    m_nb = nb; m_it = it; m_slast = sl; m_dlast = dl;
    cfg_wr(RA_SRC, s);
    cfg_wr(RA_DST, d);
    cfg_wr(RA_OFF, {dof[15:0], so[15:0]});
    cfg_wr(RA_ATTR, {ie, 4'b0, ds[2:0], 5'b0, ss[2:0], 3'b0, dm[4:0], 3'b0, sm[4:0]});
    cfg_wr(RA_NBYTES, 32'(nb));
    cfg_wr(RA_ITER, 32'(it));
    cfg_wr(RA_SLAST, sl);
    cfg_wr(RA_DLAST, dl);
  endtask

  // poke 1: extra start while busy; poke 2: descriptor write while busy
  task automatic run(input int poke, input string req);
    int cyc;
    cfg_wr(RA_STAT, 32'h7);
    model_run();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    cyc = 1;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      if (poke == 1) start = (cyc == 3);
      if (poke == 2) begin cfg_we = (cyc == 3); cfg_addr = RA_SRC; cfg_wdata = 32'h0; end
    end
    start = 0; cfg_we = 0;
    chk(cyc == 2 * beats + 1, {req, " R3 completion cycle"}, 32'(cyc), 32'(2 * beats + 1));
    chk(q_wa.size() == 0 && q_ra.size() == 0, {req, " R3 all beats issued"},
        32'(q_wa.size()), 32'h0);
  endtask

  task automatic err_try(input string req);
    cfg_wr(RA_STAT, 32'h7);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (2) @(negedge clk);
    chk(err == 1'b1, {req, " R11 err set"}, 32'(err), 32'h1);
    chk(!busy && !done, {req, " R11 no transfer"}, {30'b0, busy, done}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp8 [0:7];
    logic [31:0] exp6 [0:5];
    exp8 = '{1, 2, 3, 4, 1, 2, 3, 4};
    exp6 = '{23, 22, 21, 20, 13, 12};
    for (int i = 0; i < 256; i++) put(32'(i * 4), 32'h0);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk({busy, done, irq, err, mem_en} == 5'b0, "R1 flags after reset",
        {27'b0, busy, done, irq, err, mem_en}, 32'h0);
    cfg_rd(RA_STAT, v);
    chk(v == 32'h0, "R1 status readback", v, 32'h0);

    // R12 source replay through a 16-byte window
    for (int i = 0; i < 4; i++) put(32'h40 + 32'(i * 4), 32'(i + 1));
    prog(32'h40, 32'h100, 4, 4, 4, 0, 2, 2, 1'b1, 32, 1, 32'h0, -32'sd32);
    run(0, "R12");
    for (int i = 0; i < 8; i++)
      chk(ram[8'h40 + i] == exp8[i], "R12 destination pattern", ram[8'h40 + i], exp8[i]);
    chk(done == 1'b1, "R8 done at completion", 32'(done), 32'h1);
    chk(irq == 1'b1, "R8 irq when enabled", 32'(irq), 32'h1);
    cfg_rd(RA_SRC, v);
    chk(v == m_src, "R5 source wrapped to start", v, m_src);
    cfg_rd(RA_DST, v);
    chk(v == 32'h100, "R7 destination end correction", v, 32'h100);
    cfg_rd(RA_ITER, v);
    chk(v == 32'h0001_0001, "R6 iteration reload", v, 32'h0001_0001);

    // R9 write-one-to-clear
    cfg_wr(RA_STAT, 32'h0);
    @(negedge clk);
    chk(done && irq, "R9 zero write keeps flags", {30'b0, done, irq}, 32'h3);
    cfg_wr(RA_STAT, 32'h1);
    @(negedge clk);
    chk(!done && irq, "R9 clear done only", {30'b0, done, irq}, 32'h1);
    cfg_wr(RA_STAT, 32'h2);
    @(negedge clk);
    chk(!irq, "R9 clear irq", 32'(irq), 32'h0);

    // R5 destination held in an 8-byte ring, irq disabled
    for (int i = 0; i < 4; i++) put(32'h200 + 32'(i * 4), 32'(10 + i));
    put(32'h310, 32'h55);
    prog(32'h200, 32'h308, 4, 4, 0, 3, 2, 2, 1'b0, 16, 1, 32'h0, 32'h0);
    run(0, "R5");
    chk(ram[8'hC2] == 32'd12, "R5 ring slot 0", ram[8'hC2], 32'd12);
    chk(ram[8'hC3] == 32'd13, "R5 ring slot 1", ram[8'hC3], 32'd13);
    chk(ram[8'hC4] == 32'h55, "R5 outside ring untouched", ram[8'hC4], 32'h55);
    chk(done && !irq, "R8 irq stays low when disabled", {30'b0, done, irq}, 32'h2);
    cfg_rd(RA_DST, v);
    chk(v == m_dst, "R5 destination ring address", v, m_dst);

    // R4/R6/R7 descending source, three iterations
    for (int i = 0; i < 4; i++) put(32'h210 + 32'(i * 4), 32'(20 + i));
    prog(32'h21C, 32'h380, -4, 4, 0, 0, 2, 2, 1'b1, 8, 3, 32'd24, -32'sd24);
    run(0, "R6");
    for (int i = 0; i < 6; i++)
      chk(ram[8'hE0 + i] == exp6[i], "R4 descending copy", ram[8'hE0 + i], exp6[i]);
    cfg_rd(RA_SRC, v);
    chk(v == 32'h21C, "R7 source end correction", v, 32'h21C);
    cfg_rd(RA_DST, v);
    chk(v == 32'h380, "R7 destination end correction", v, 32'h380);
    cfg_rd(RA_ITER, v);
    chk(v == 32'h0003_0003, "R6 current count reloaded", v, 32'h0003_0003);

    // R10 start while busy ignored (timing and beat count checked in run)
    run(1, "R10");
    // R2 descriptor write during transfer ignored
    run(2, "R2");
    cfg_rd(RA_SRC, v);
    chk(v == m_src, "R2 busy write ignored", v, m_src);

    // R11 configuration errors
    prog(32'h40, 32'h100, 4, 4, 0, 0, 2, 2, 1'b1, 6, 1, 32'h0, 32'h0);
    err_try("R11 odd byte count");
    cfg_wr(RA_STAT, 32'h4);
    @(negedge clk);
    chk(!err, "R9 clear err", 32'(err), 32'h0);
    prog(32'h40, 32'h100, 4, 4, 0, 0, 1, 2, 1'b1, 8, 1, 32'h0, 32'h0);
    err_try("R11 bad size code");
    prog(32'h40, 32'h100, 4, 4, 0, 0, 2, 2, 1'b1, 8, 0, 32'h0, 32'h0);
    err_try("R11 zero iterations");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule